// File: doc/BRIEF.md
# Quad I/O Serial Flash Read Sequencer

This block sits on the host side of a serial NOR flash and fetches bytes with the quad-I/O fast read command. A one-cycle request carries a 24-bit start address, a byte count and a flag that decides whether the flash should stay in continuous read mode afterwards. The sequencer then lowers chip select, runs the serial clock from a divided system clock, and sends the command, address and mode byte. It releases the four IO lines for the dummy clocks and collects the returned nibbles into bytes. Each byte appears on `rd_data_o` with a one-cycle `rd_valid_o` strobe.

An internal flag records whether the last mode byte asked the flash to stay in continuous mode. While the flag is set, the next read leaves out the 8-clock command phase and begins with the address. A separate request sends a mode reset, which holds all four lines high for 8 clocks and clears the flag. The serial clock idles low (SPI mode 0). Outputs change with the falling SCK edge, and inputs are sampled on the rising edge.

Top module: `qio_flash_reader`

## Requirements
- R1: After reset, `cs_no` is 1, `sck_o` is 0, `io_oe_o` is 4'b0000, `busy_o` is 0 and `rd_valid_o` is 0.
- R2: When the continuous flag is clear, a read starts with 8 SCK clocks that carry 8'hEB on `io_o[0]`, MSB first, with `io_oe_o` = 4'b0001.
- R3: The address phase lasts 6 SCK clocks with `io_oe_o` = 4'b1111. Each clock carries one nibble of the start address, most significant nibble first, with `io_o[3]` holding the nibble's top bit.
- R4: Two clocks then carry the mode byte, high nibble first: 8'hA0 when `rd_keep_i` was 1 at request time, and 8'h00 otherwise.
- R5: During the 4 dummy clocks that follow, and for the whole data phase, `io_oe_o` is 4'b0000.
- R6: A read of N bytes (N ≥ 1) has 2N data clocks. Each byte is assembled from the `io_i` values sampled on two rising SCK edges, high nibble first. It is presented with a one-cycle `rd_valid_o`. After the last data clock, chip select rises and `done_o` pulses for one cycle.
- R7: If the previous mode byte was 8'hA0, the next read has no command phase and lasts 12+2N SCK clocks. Otherwise it lasts 20+2N clocks.
- R8: A mode-reset request produces exactly 8 SCK clocks under chip select, with `io_o` = 4'hF and `io_oe_o` = 4'hF on every clock. It clears the continuous flag, so the next read includes the command phase.
- R9: Rising SCK edges within a transaction are exactly `CLK_DIV` system clocks apart. `io_o` and `io_oe_o` do not change while SCK is high.
- R10: Read and mode-reset requests that arrive while `busy_o` is 1 are ignored and start no transaction.
- R11: While `cs_no` is 1, `sck_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_req_i | input | 1 | One-cycle read request, taken when idle |
| rd_addr_i | input | 24 | Start address of the read |
| rd_len_i | input | LEN_W | Number of bytes to read (0 is treated as 1) |
| rd_keep_i | input | 1 | 1: send mode byte A0h (stay continuous), 0: send 00h |
| mrst_req_i | input | 1 | One-cycle mode-reset request, taken when idle; wins over a read |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when a transaction ends |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | `rd_data_o` holds a new byte |
| sck_o | output | 1 | Serial clock to the flash |
| cs_no | output | 1 | Active-low chip select |
| io_o | output | 4 | Values driven on IO3..IO0 |
| io_oe_o | output | 4 | Per-line output enable |
| io_i | input | 4 | Values sampled from IO3..IO0 |

## Verification
The assertions assume the flash changes `io_i` only after a falling SCK edge and holds it through the following rising edge. They also assume requests are single-cycle pulses, byte counts are nonzero and `CLK_DIV` is at least 2. The bench's flash model drives its next nibble only once it has seen SCK fall. It keeps its own continuous-mode state, decoded from the mode bits it receives. Every request in the bench is raised for exactly one cycle between clock edges, with a length of one or more. Requests aimed at a busy sequencer exist only to show that they are dropped.

// File: rtl/qio_pkg.sv
package qio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_MRST
  } phase_e;

  localparam logic [7:0] CMD_QIO   = 8'hEB;
  localparam logic [7:0] MODE_KEEP = 8'hA0;
  localparam logic [7:0] MODE_EXIT = 8'h00;

  localparam int unsigned CMD_CLKS   = 8;
  localparam int unsigned ADDR_CLKS  = 6;
  localparam int unsigned MODE_CLKS  = 2;
  localparam int unsigned DUMMY_CLKS = 4;
  localparam int unsigned MRST_CLKS  = 8;

endpackage

// File: rtl/qio_sck_gen.sv
module qio_sck_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned HALF = CLK_DIV / 2;

  logic [CW-1:0] cnt_q;
  logic          sck_q;

  assign rise_o = run_i && (cnt_q == CW'(HALF - 1));
  assign fall_o = run_i && (cnt_q == CW'(CLK_DIV - 1));
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + CW'(1);
      if (rise_o)      sck_q <= 1'b1;
      else if (fall_o) sck_q <= 1'b0;
    end
  end

  p_edge_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

  p_fall_from_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> sck_q);

endmodule

// File: rtl/qio_byte_asm.sv
module qio_byte_asm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic       low_i,
  input  logic [3:0] nib_i,
  output logic [7:0] data_o,
  output logic       valid_o
);

  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        if (!low_i) begin
          hi_q <= nib_i;
        end else begin
          data_o  <= {hi_q, nib_i};
          valid_o <= 1'b1;
        end
      end
    end
  end

  // two SCK clocks per byte, so strobes never touch
  p_valid_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

endmodule

// File: rtl/qio_flash_reader.sv
module qio_flash_reader
  import qio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned LEN_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic [23:0]      rd_addr_i,
  input  logic [LEN_W-1:0] rd_len_i,
  input  logic             rd_keep_i,
  input  logic             mrst_req_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);

  phase_e           phase_q, phase_nxt;
  logic [2:0]       cyc_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] rem_q;
  logic             keep_q;
  logic             cont_q;
  logic             done_q;
  logic             run;
  logic             sck_rise, sck_fall;
  logic             last_clk;
  logic [23:0]      addr_sh;
  logic [7:0]       mode_b;

  assign run    = (phase_q != PH_IDLE);
  assign busy_o = run;
  assign cs_no  = !run;
  assign done_o = done_q;

  qio_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sck_o  (sck_o),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  qio_byte_asm u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (sck_rise && (phase_q == PH_DATA)),
    .low_i   (cyc_q[0]),
    .nib_i   (io_i),
    .data_o  (rd_data_o),
    .valid_o (rd_valid_o)
  );

  always_comb begin
    last_clk  = 1'b0;
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_CMD:   begin last_clk = (cyc_q == 3'(CMD_CLKS - 1));   phase_nxt = PH_ADDR;  end
      PH_ADDR:  begin last_clk = (cyc_q == 3'(ADDR_CLKS - 1));  phase_nxt = PH_MODE;  end
      PH_MODE:  begin last_clk = (cyc_q == 3'(MODE_CLKS - 1));  phase_nxt = PH_DUMMY; end
      PH_DUMMY: begin last_clk = (cyc_q == 3'(DUMMY_CLKS - 1)); phase_nxt = PH_DATA;  end
      PH_DATA:  begin last_clk = cyc_q[0] && (rem_q == LEN_W'(1)); phase_nxt = PH_IDLE; end
      PH_MRST:  begin last_clk = (cyc_q == 3'(MRST_CLKS - 1));  phase_nxt = PH_IDLE;  end
      default:  begin last_clk = 1'b0; phase_nxt = PH_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      keep_q  <= 1'b0;
      cont_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        cyc_q <= '0;
        if (mrst_req_i) begin
          phase_q <= PH_MRST;
        end else if (rd_req_i) begin
          phase_q <= cont_q ? PH_ADDR : PH_CMD;
          addr_q  <= rd_addr_i;
          rem_q   <= (rd_len_i == '0) ? LEN_W'(1) : rd_len_i;
          keep_q  <= rd_keep_i;
        end
      end else if (sck_fall) begin
        if (last_clk) begin
          phase_q <= phase_nxt;
          cyc_q   <= '0;
          if (phase_q == PH_MODE) cont_q <= keep_q;
          if (phase_q == PH_MRST) cont_q <= 1'b0;
          if (phase_nxt == PH_IDLE) done_q <= 1'b1;
        end else begin
          cyc_q <= cyc_q + 3'd1;
          if (phase_q == PH_DATA && cyc_q[0]) rem_q <= rem_q - LEN_W'(1);
        end
      end
    end
  end

  // IO drive: all sources are registers that move on the falling SCK edge
  assign addr_sh = addr_q << {cyc_q, 2'b00};
  assign mode_b  = keep_q ? MODE_KEEP : MODE_EXIT;

  always_comb begin
    io_o    = 4'h0;
    io_oe_o = 4'h0;
    unique case (phase_q)
      PH_CMD:  begin io_o = {3'b000, CMD_QIO[3'd7 - cyc_q]}; io_oe_o = 4'b0001; end
      PH_ADDR: begin io_o = addr_sh[23:20]; io_oe_o = 4'hF; end
      PH_MODE: begin io_o = cyc_q[0] ? mode_b[3:0] : mode_b[7:4]; io_oe_o = 4'hF; end
      PH_MRST: begin io_o = 4'hF; io_oe_o = 4'hF; end
      default: begin io_o = 4'h0; io_oe_o = 4'h0; end
    endcase
  end

  p_sck_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  p_io_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> ($stable(io_o) && $stable(io_oe_o)));

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DUMMY || phase_q == PH_DATA) |-> (io_oe_o == 4'h0));

  p_valid_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !cs_no);

  p_cont_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cont_q) |-> ($past(phase_q) == PH_MODE));

  p_cont_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cont_q) |-> ($past(phase_q) == PH_MODE || $past(phase_q) == PH_MRST));

  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_q && !$past(done_q) && $past(busy_o)) |-> $stable(addr_q));

endmodule

// File: tb/qio_flash_reader_test.sv
module qio_flash_reader_test;
  localparam int unsigned DIV   = 4;
  localparam int unsigned LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_req = 1'b0;
  logic [23:0]      rd_addr = '0;
  logic [LEN_W-1:0] rd_len = '0;
  logic             rd_keep = 1'b0;
  logic             mrst_req = 1'b0;
  logic             busy, done, rd_valid, sck, cs_n;
  logic [7:0]       rd_data;
  logic [3:0]       io_out, io_oe;
  logic [3:0]       io_in = 4'h0;

  always #4 clk = ~clk;

  qio_flash_reader #(.CLK_DIV(DIV), .LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_len_i(rd_len), .rd_keep_i(rd_keep), .mrst_req_i(mrst_req),
    .busy_o(busy), .done_o(done), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .sck_o(sck), .cs_no(cs_n), .io_o(io_out), .io_oe_o(io_oe), .io_i(io_in)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // flash model and bus monitor
  logic        f_cont = 1'b0;
  logic        s_cont = 1'b0;
  logic [7:0]  s_cmd, s_mode;
  logic [23:0] s_addr;
  logic        s_oe_bad, s_allhigh, s_per_bad;
  int          k = 0, s_k = 0, sess_cnt = 0, cyc_cnt = 0, last_rise = -1;
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  logic [7:0]  rx_buf [64];
  int          rx_n = 0;

  always @(negedge clk) begin
    int base;
    cyc_cnt++;
    if (!cs_n && prev_cs) begin
      k = 0; s_cont = f_cont; s_cmd = '0; s_addr = '0; s_mode = '0;
      s_oe_bad = 1'b0; s_allhigh = 1'b1; s_per_bad = 1'b0; last_rise = -1;
      io_in = 4'h0;
    end
    base = s_cont ? 0 : 8;
    if (!cs_n && sck && !prev_sck) begin
      if (last_rise >= 0 && (cyc_cnt - last_rise) != DIV) s_per_bad = 1'b1;
      last_rise = cyc_cnt;
      if (io_out != 4'hF || io_oe != 4'hF) s_allhigh = 1'b0;
      if (k < base) begin
        s_cmd = {s_cmd[6:0], io_out[0]};
        if (io_oe != 4'b0001) s_oe_bad = 1'b1;
      end else if (k < base + 6) begin
        s_addr = {s_addr[19:0], io_out};
        if (io_oe != 4'hF) s_oe_bad = 1'b1;
      end else if (k < base + 8) begin
        s_mode = {s_mode[3:0], io_out};
        if (io_oe != 4'hF) s_oe_bad = 1'b1;
        if (k == base + 7 && (s_cont || s_cmd == 8'hEB))
          f_cont = (s_mode[5:4] == 2'b10);
      end else begin
        if (io_oe != 4'h0) s_oe_bad = 1'b1;
      end
      k++;
    end
    if (!cs_n && !sck && prev_sck) begin
      if (k >= base + 12) begin
        int d;
        logic [7:0] b;
        d = k - base - 12;
        b = pat(s_addr + 24'(d / 2));
        io_in = d[0] ? b[3:0] : b[7:4];
      end else begin
        io_in = 4'h0;
      end
    end
    if (cs_n && !prev_cs) begin
      s_k = k;
      sess_cnt++;
    end
    if (rd_valid) begin
      if (rx_n < 64) rx_buf[rx_n] = rd_data;
      rx_n++;
    end
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL %s watchdog actual=busy expected=done", tag);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [23:0] a, input int len, input logic keep,
                         input logic exp_cmd, input logic poke);
    int rx0, ss0;
    @(negedge clk);
    rx0 = rx_n; ss0 = sess_cnt;
    rd_addr = a; rd_len = LEN_W'(len); rd_keep = keep; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      rd_addr = 24'hFFFFFF; rd_req = 1'b1; mrst_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0; mrst_req = 1'b0;
    end
    wait_done("R6");
    if (poke) repeat (40) @(negedge clk);
    chk("R7 command phase present", 32'(!s_cont), 32'(exp_cmd));
    if (exp_cmd) chk("R2 command byte", 32'(s_cmd), 32'hEB);
    chk("R3 address", 32'(s_addr), 32'(a));
    chk("R4 mode byte", 32'(s_mode), keep ? 32'hA0 : 32'h00);
    chk("R5 output enables", 32'(s_oe_bad), 32'd0);
    chk("R7 SCK clocks", 32'(s_k), 32'((exp_cmd ? 8 : 0) + 12 + 2 * len));
    chk("R6 byte count", 32'(rx_n - rx0), 32'(len));
    for (int i = 0; i < len; i++)
      chk("R6 data byte", 32'(rx_buf[rx0 + i]), 32'(pat(a + 24'(i))));
    chk("R9 SCK period", 32'(s_per_bad), 32'd0);
    chk(poke ? "R10 sessions while busy" : "R6 one session", 32'(sess_cnt - ss0), 32'd1);
    chk("R11 idle clock", 32'({cs_n, sck}), 32'b10);
  endtask

  task automatic do_mrst();
    int ss0;
    @(negedge clk);
    ss0 = sess_cnt;
    mrst_req = 1'b1;
    @(negedge clk);
    mrst_req = 1'b0;
    wait_done("R8");
    chk("R8 reset clocks", 32'(s_k), 32'd8);
    chk("R8 all lines high", 32'(s_allhigh), 32'd1);
    chk("R8 one session", 32'(sess_cnt - ss0), 32'd1);
  endtask

  // {addr, len, keep, expect command phase}
  localparam int NV = 6;
  localparam logic [33:0] VECS [NV] = '{
    {24'h000010, 8'd4, 1'b1, 1'b1},
    {24'h000123, 8'd3, 1'b1, 1'b0},
    {24'hABCDEF, 8'd1, 1'b0, 1'b0},
    {24'h7FFFFE, 8'd5, 1'b0, 1'b1},
    {24'h00FF00, 8'd2, 1'b1, 1'b1},
    {24'h123456, 8'd2, 1'b1, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 32'({cs_n, sck, io_oe, busy, rd_valid}), 32'b1_0_0000_0_0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", 32'({cs_n, sck, io_oe, busy, rd_valid}), 32'b1_0_0000_0_0);

    for (int v = 0; v < NV; v++)
      do_read(VECS[v][33:10], int'(VECS[v][9:2]), VECS[v][1], VECS[v][0], 1'b0);

    do_mrst();
    do_read(24'h000400, 3, 1'b0, 1'b1, 1'b1);  // R8 command back, R10 poke ignored
    do_mrst();
    do_read(24'hFEDCBA, 1, 1'b0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule